// File: doc/BRIEF.md
# Indexed Host Register Window

This block is the host-facing register space of a two-channel line card. The host sees 32 byte addresses. A few of them hold card-level registers: the interrupt status and control byte, an auxiliary control byte and a resource index. The upper sixteen bytes form a shared data window. The value held in the index register decides which internal resource answers through that window. The resources are the two framing channels, the line-controller FIFO, and the low and high banks of the line-controller register file.

Window accesses are passed on the cycle they arrive to the selected resource. The block raises a one-cycle strobe for that resource and drives a shared write-enable, byte offset and write-data bus. Read data comes back combinationally from the resource and is registered into the host read port. The block also gathers the interrupt sources of the card into an active-low status byte. It runs an interval timer whose pending flag is cleared by pulsing a control bit, and it drives one active-low interrupt line that other cards may share.

Top module: `iowin_top`

## Requirements
- R1: After reset the index register reads 0x00, the auxiliary byte reads 0x00 and the status byte reads 0x07 when no source is active. The interrupt line is high, the downstream reset and test outputs are low, no strobe is active and the host read port holds 0xFF.
- R2: In the window (addresses 0x10 to 0x1F), index 0x00 routes to channel 0 (`ch_stb[0]`), 0x01 to channel 1 (`ch_stb[1]`), 0x02 to the line-controller FIFO (`lcf_stb`), and 0x04 or 0x06 to the line-controller register file (`lcr_stb`), with `lcr_hi` high only for 0x06. Any other index routes to nothing. At most one strobe is active at a time.
- R3: A framing channel answers window bytes 0 to 7, where bytes 0 to 3 are its FIFO and bytes 4 to 7 are its status and control word. The line-controller FIFO answers byte 0 only. Each register bank answers all sixteen bytes. Other bytes raise no strobe.
- R4: A strobe is raised combinationally in the same cycle as the host read or write. In that cycle `dn_off` equals address bits 3:0, `dn_we` equals the host write and `dn_wdata` equals the host write data.
- R5: Host read data appears on `host_rdata` one clock after the read cycle. It is 0xFF for reserved addresses (0x00, 0x01 and 0x05 to 0x0F) and for window bytes that no resource answers.
- R6: Address 0x02 reads as the status byte. Bit 0 is the line-controller source, bit 1 is any framing channel and bit 2 is the timer. Each is 0 while its source is pending. Bits 7:3 read 0.
- R7: Writing address 0x02 loads the control bits: bit 0 downstream reset (`dn_reset`), bit 1 timer stop, bit 2 timer clear, bit 3 interrupt enable, bit 4 test (`test_mode`). They take effect from the next clock.
- R8: Address 0x03 stores bits 3:0 as the interrupt select (`aux_isel`) and bit 7 as the serial bus enable (`aux_bus_en`). It reads back with bits 6:4 as 0.
- R9: `irq_n` goes low one clock after the interrupt enable is 1 and at least one source is pending. Otherwise it is high.
- R10: While the timer is neither stopped nor held by the clear bit, its pending flag sets TMR_PERIOD clocks after it was released. When stopped, it never sets.
- R11: A pending timer flag is cleared only by writing the clear bit as 1 and then back to 0. Writing the 1 alone leaves the flag set.
- R12: Writes to reserved addresses change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Host byte address |
| host_wr | input | 1 | Host write cycle |
| host_rd | input | 1 | Host read cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq_n | output | 1 | Shared interrupt line, active low |
| fr_irq | input | 2 | Framing channel interrupt requests, active high |
| lc_irq | input | 1 | Line-controller interrupt request, active high |
| ch_stb | output | 2 | Framing channel access strobes |
| lcf_stb | output | 1 | Line-controller FIFO access strobe |
| lcr_stb | output | 1 | Line-controller register access strobe |
| lcr_hi | output | 1 | High register bank selected |
| dn_we | output | 1 | Downstream write enable |
| dn_off | output | 4 | Downstream byte offset in the window |
| dn_wdata | output | 8 | Downstream write data |
| ch_rdata | input | 16 | Read data of channel 1 (15:8) and channel 0 (7:0) |
| lcf_rdata | input | 8 | Line-controller FIFO read data |
| lcr_rdata | input | 8 | Line-controller register read data |
| dn_reset | output | 1 | Reset held on all downstream resources |
| test_mode | output | 1 | Test control bit |
| aux_isel | output | 4 | Interrupt select field |
| aux_bus_en | output | 1 | Serial inter-chip bus enable |

## Verification
Strobes and the shared downstream bus are combinational. The bench samples them shortly after driving a cycle and before its clock edge. Register writes, `irq_n` and the host read data all change on the edge that ends the cycle, so the bench samples them at the following falling edge. The timer flag sets on the TMR_PERIOD-th edge after the clear bit is released. The bench therefore reads the status once with its capture edge one clock before that point and expects no pending flag. It then reads again with its capture edge one clock after that point and expects the flag.

// File: rtl/iowin_pkg.sv
// Shared constants of the indexed host register window.
// Assumes a 32-byte host space whose upper half is the data window.
package iowin_pkg;
    localparam int ADDR_W   = 5;
    localparam int WIN_W    = 4;
    localparam int DATA_W   = 8;
    localparam int CTL_W    = 5;
    localparam int AUX_W    = 5;

    // Card-level register addresses
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h02;
    localparam logic [ADDR_W-1:0] A_AUX    = 5'h03;
    localparam logic [ADDR_W-1:0] A_INDEX  = 5'h04;

    // Index codes
    localparam logic [DATA_W-1:0] IX_LCF  = 8'h02;
    localparam logic [DATA_W-1:0] IX_LCRL = 8'h04;
    localparam logic [DATA_W-1:0] IX_LCRH = 8'h06;

    // Control bit positions
    localparam int CB_RST  = 0;
    localparam int CB_TSTOP = 1;
    localparam int CB_TCLR = 2;
    localparam int CB_IEN  = 3;
    localparam int CB_TEST = 4;

    localparam logic [CTL_W-1:0] CTL_RST_VAL = 5'b00010;
    localparam logic [DATA_W-1:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/iowin_decode.sv
// Holds the index register and decodes window accesses into resource selects.
// Assumes at most one resource answers any window byte; sel_vec is not gated
// by an access, strobes are.
module iowin_decode
    import iowin_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] idx_q,
    output logic [NCH+1:0]    sel_vec,
    output logic [NCH+1:0]    stb_vec,
    output logic              lcr_hi
);
    logic [WIN_W-1:0] woff;
    logic             win_acc;
    logic             chan_byte;

    assign woff      = host_addr[WIN_W-1:0];
    assign win_acc   = host_addr[ADDR_W-1] & (host_wr | host_rd);
    assign chan_byte = ~woff[WIN_W-1];

    // Index register: loaded by host writes to its address
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (host_wr && host_addr == A_INDEX)
            idx_q <= host_wdata;
    end

    // One select per framing channel, index code equal to channel number
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign sel_vec[k] = (idx_q == DATA_W'(k)) & chan_byte;
    end

    // Line-controller FIFO answers byte 0, register banks all bytes
    assign sel_vec[NCH]   = (idx_q == IX_LCF) & (woff == '0);
    assign sel_vec[NCH+1] = (idx_q == IX_LCRL) | (idx_q == IX_LCRH);
    assign lcr_hi         = (idx_q == IX_LCRH);

    // Strobes only during a window access
    assign stb_vec = sel_vec & {(NCH+2){win_acc}};
endmodule

// File: rtl/iowin_ctrl.sv
// Control and auxiliary registers, interval timer and interrupt gathering.
// Assumes source inputs are synchronous and active high.
module iowin_ctrl
    import iowin_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int TMR_PERIOD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_aux,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [AUX_W-1:0]  aux_wdata,
    input  logic [NCH-1:0]    fr_irq,
    input  logic              lc_irq,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic              tmr_pend,
    output logic [DATA_W-1:0] status,
    output logic              irq_n
);
    localparam int CNT_W = (TMR_PERIOD > 1) ? $clog2(TMR_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMR_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             clr_fall;
    logic             any_src;

    assign run      = ~ctl_q[CB_TSTOP] & ~ctl_q[CB_TCLR];
    assign clr_fall = wr_ctl & ctl_q[CB_TCLR] & ~ctl_wdata[CB_TCLR];
    assign any_src  = lc_irq | (|fr_irq) | tmr_pend;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RST_VAL;
        else if (wr_ctl)
            ctl_q <= ctl_wdata;
    end

    // Auxiliary register
    always_ff @(posedge clk) begin
        if (!rst_n)
            aux_q <= '0;
        else if (wr_aux)
            aux_q <= aux_wdata;
    end

    // Interval counter, held at zero while stopped or cleared
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == CNT_LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Timer pending flag, cleared on the falling write of the clear bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_pend <= 1'b0;
        else if (clr_fall)
            tmr_pend <= 1'b0;
        else if (run && cnt_q == CNT_LAST)
            tmr_pend <= 1'b1;
    end

    // Shared interrupt line, registered
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~(ctl_q[CB_IEN] & any_src);
    end

    assign status = {{(DATA_W-3){1'b0}}, ~tmr_pend, ~(|fr_irq), ~lc_irq};
endmodule

// File: rtl/iowin_rdmux.sv
// Registers the host read data from card registers or the selected resource.
// Assumes resource read data is valid combinationally in the access cycle.
module iowin_rdmux
    import iowin_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_rd,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [NCH+1:0]          sel_vec,
    input  logic [(NCH+2)*DATA_W-1:0] res_rdata,
    input  logic [DATA_W-1:0]       status,
    input  logic [AUX_W-1:0]        aux_q,
    input  logic [DATA_W-1:0]       idx_q,
    output logic [DATA_W-1:0]       host_rdata
);
    logic [DATA_W-1:0] part [NCH+2];
    logic [DATA_W-1:0] win_data;
    logic [DATA_W-1:0] next_data;

    // Mask each resource's byte with its select
    for (genvar k = 0; k < NCH + 2; k++) begin : g_mask
        assign part[k] = res_rdata[k*DATA_W +: DATA_W] & {DATA_W{sel_vec[k]}};
    end

    // OR the masked bytes together; idle byte when nothing answers
    always_comb begin
        win_data = '0;
        for (int k = 0; k < NCH + 2; k++)
            win_data = win_data | part[k];
        if (sel_vec == '0)
            win_data = IDLE_BYTE;
    end

    // Address decode of the read source
    always_comb begin
        if (host_addr[ADDR_W-1])
            next_data = win_data;
        else if (host_addr == A_STATUS)
            next_data = status;
        else if (host_addr == A_AUX)
            next_data = {aux_q[AUX_W-1], 3'b000, aux_q[AUX_W-2:0]};
        else if (host_addr == A_INDEX)
            next_data = idx_q;
        else
            next_data = IDLE_BYTE;
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= IDLE_BYTE;
        else if (host_rd)
            host_rdata <= next_data;
    end
endmodule

// File: rtl/iowin_top.sv
// Indexed host register window of a two-channel line card.
// Assumes one host access per cycle and combinational resource read data.
module iowin_top
    import iowin_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int TMR_PERIOD = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4:0]            host_addr,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic                  irq_n,
    input  logic [NCH-1:0]        fr_irq,
    input  logic                  lc_irq,
    output logic [NCH-1:0]        ch_stb,
    output logic                  lcf_stb,
    output logic                  lcr_stb,
    output logic                  lcr_hi,
    output logic                  dn_we,
    output logic [3:0]            dn_off,
    output logic [7:0]            dn_wdata,
    input  logic [NCH*8-1:0]      ch_rdata,
    input  logic [7:0]            lcf_rdata,
    input  logic [7:0]            lcr_rdata,
    output logic                  dn_reset,
    output logic                  test_mode,
    output logic [3:0]            aux_isel,
    output logic                  aux_bus_en
);
    logic [DATA_W-1:0] idx_q;
    logic [NCH+1:0]    sel_vec;
    logic [NCH+1:0]    stb_vec;
    logic [CTL_W-1:0]  ctl_q;
    logic [AUX_W-1:0]  aux_q;
    logic              tmr_pend;
    logic [DATA_W-1:0] status;
    logic              wr_ctl;
    logic              wr_aux;

    assign wr_ctl = host_wr & (host_addr == A_STATUS);
    assign wr_aux = host_wr & (host_addr == A_AUX);

    iowin_decode #(.NCH(NCH)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .idx_q      (idx_q),
        .sel_vec    (sel_vec),
        .stb_vec    (stb_vec),
        .lcr_hi     (lcr_hi)
    );

    iowin_ctrl #(.NCH(NCH), .TMR_PERIOD(TMR_PERIOD)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wr_aux    (wr_aux),
        .ctl_wdata (host_wdata[CTL_W-1:0]),
        .aux_wdata ({host_wdata[7], host_wdata[3:0]}),
        .fr_irq    (fr_irq),
        .lc_irq    (lc_irq),
        .ctl_q     (ctl_q),
        .aux_q     (aux_q),
        .tmr_pend  (tmr_pend),
        .status    (status),
        .irq_n     (irq_n)
    );

    iowin_rdmux #(.NCH(NCH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .sel_vec    (sel_vec),
        .res_rdata  ({lcr_rdata, lcf_rdata, ch_rdata}),
        .status     (status),
        .aux_q      (aux_q),
        .idx_q      (idx_q),
        .host_rdata (host_rdata)
    );

    assign ch_stb     = stb_vec[NCH-1:0];
    assign lcf_stb    = stb_vec[NCH];
    assign lcr_stb    = stb_vec[NCH+1];
    assign dn_we      = host_wr;
    assign dn_off     = host_addr[WIN_W-1:0];
    assign dn_wdata   = host_wdata;
    assign dn_reset   = ctl_q[CB_RST];
    assign test_mode  = ctl_q[CB_TEST];
    assign aux_isel   = aux_q[AUX_W-2:0];
    assign aux_bus_en = aux_q[AUX_W-1];
endmodule

// File: rtl/iowin_chk.sv
// Property checker for iowin_top, attached by bind.
// Assumes the top-level nets tmr_pend and ctl_q are visible in the bound scope.
module iowin_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [4:0]     host_addr,
    input logic           host_wr,
    input logic           host_rd,
    input logic [7:0]     host_wdata,
    input logic [7:0]     host_rdata,
    input logic           irq_n,
    input logic [NCH-1:0] fr_irq,
    input logic           lc_irq,
    input logic [NCH-1:0] ch_stb,
    input logic           lcf_stb,
    input logic           lcr_stb,
    input logic           dn_reset,
    input logic           tmr_pend,
    input logic [4:0]     ctl_q
);
    logic any_stb;
    logic rsv_addr;

    assign any_stb  = (|ch_stb) | lcf_stb | lcr_stb;
    assign rsv_addr = ~host_addr[4] & (host_addr != 5'h02) &
                      (host_addr != 5'h03) & (host_addr != 5'h04);

    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_stb, lcf_stb, lcr_stb}));

    assert_stb_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> (host_addr[4] && (host_rd || host_wr)));

    assert_rsv_reads_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rsv_addr) |=> (host_rdata == 8'hFF));

    assert_rst_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_reset) |-> $past(host_wr && host_addr == 5'h02 && host_wdata[0]));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(ctl_q[3] && (lc_irq || (|fr_irq) || tmr_pend)));

    assert_tmr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_pend) |-> $fell(ctl_q[2]));

    assert_rsv_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && rsv_addr) |=> $stable(ctl_q));
endmodule

bind iowin_top iowin_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_n      (irq_n),
    .fr_irq     (fr_irq),
    .lc_irq     (lc_irq),
    .ch_stb     (ch_stb),
    .lcf_stb    (lcf_stb),
    .lcr_stb    (lcr_stb),
    .dn_reset   (dn_reset),
    .tmr_pend   (tmr_pend),
    .ctl_q      (ctl_q)
);

// File: tb/iowin_top_test.sv
// Self-checking bench for iowin_top: directed corners plus seeded random
// window traffic, with expected values computed from the requirements.
module iowin_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMR        = 32;
    localparam int SEED       = 1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_n;
    logic [1:0] fr_irq = '0;
    logic       lc_irq = 1'b0;
    logic [1:0] ch_stb;
    logic       lcf_stb, lcr_stb, lcr_hi, dn_we;
    logic [3:0] dn_off;
    logic [7:0] dn_wdata;
    logic [15:0] ch_rdata;
    logic [7:0] lcf_rdata, lcr_rdata;
    logic       dn_reset, test_mode, aux_bus_en;
    logic [3:0] aux_isel;

    int checks = 0;
    int errors = 0;

    // Resource models: answer with a pattern tied to resource and offset
    assign ch_rdata  = {4'h2, dn_off, 4'h1, dn_off};
    assign lcf_rdata = 8'h3C;
    assign lcr_rdata = {3'b010, lcr_hi, dn_off};

    iowin_top #(.NCH(2), .TMR_PERIOD(TMR)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_n(irq_n), .fr_irq(fr_irq), .lc_irq(lc_irq), .ch_stb(ch_stb),
        .lcf_stb(lcf_stb), .lcr_stb(lcr_stb), .lcr_hi(lcr_hi), .dn_we(dn_we),
        .dn_off(dn_off), .dn_wdata(dn_wdata), .ch_rdata(ch_rdata),
        .lcf_rdata(lcf_rdata), .lcr_rdata(lcr_rdata), .dn_reset(dn_reset),
        .test_mode(test_mode), .aux_isel(aux_isel), .aux_bus_en(aux_bus_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0] snap_stb;
    logic [3:0] snap_off;
    logic       snap_we;
    logic [7:0] snap_wd;
    logic [7:0] rd_val;

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host cycle; called and returns at a falling edge
    task automatic access(input bit w, input logic [4:0] a, input logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = w;
        host_rd    = ~w;
        #1;
        snap_stb = {lcr_stb, lcf_stb, ch_stb};
        snap_off = dn_off;
        snap_we  = dn_we;
        snap_wd  = dn_wdata;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
        rd_val  = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected window read for index and byte (R2, R3)
    function automatic logic [7:0] win_exp(input logic [7:0] ix, input logic [3:0] o);
        if (ix == 8'h00 && o < 8)       return {4'h1, o};
        else if (ix == 8'h01 && o < 8)  return {4'h2, o};
        else if (ix == 8'h02 && o == 0) return 8'h3C;
        else if (ix == 8'h04)           return {4'h4, o};
        else if (ix == 8'h06)           return {4'h5, o};
        else                            return 8'hFF;
    endfunction

    // Expected strobe vector {lcr, lcf, ch1, ch0}
    function automatic logic [3:0] stb_exp(input logic [7:0] ix, input logic [3:0] o);
        if (ix == 8'h00 && o < 8)       return 4'b0001;
        else if (ix == 8'h01 && o < 8)  return 4'b0010;
        else if (ix == 8'h02 && o == 0) return 4'b0100;
        else if (ix == 8'h04 || ix == 8'h06) return 4'b1000;
        else                            return 4'b0000;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ix;
        logic [3:0] o;
        logic [7:0] d;
        bit         w;
        void'($urandom(SEED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
        check(dn_reset === 1'b0 && test_mode === 1'b0, "R1 ctl outputs", {dn_reset, test_mode}, 0);
        check(host_rdata === 8'hFF, "R1 rdata", host_rdata, 8'hFF);
        check({lcr_stb, lcf_stb, ch_stb} === 4'b0, "R1 strobes", {lcr_stb, lcf_stb, ch_stb}, 0);
        access(0, 5'h04, 0);
        check(rd_val === 8'h00, "R1 index", rd_val, 0);
        access(0, 5'h03, 0);
        check(rd_val === 8'h00, "R1 aux", rd_val, 0);
        access(0, 5'h02, 0);
        check(rd_val === 8'h07, "R1 status", rd_val, 8'h07);

        // R2/R3 corners: FIFO byte 0 vs 1, channel byte 7 vs 8, high bank
        access(1, 5'h04, 8'h02);
        access(0, 5'h10, 0);
        check(rd_val === 8'h3C && snap_stb === 4'b0100, "R3 lcf byte0", {snap_stb, rd_val}, 16'h43C);
        access(0, 5'h11, 0);
        check(rd_val === 8'hFF && snap_stb === 4'b0000, "R3 lcf byte1", {snap_stb, rd_val}, 16'h0FF);
        access(1, 5'h04, 8'h01);
        access(0, 5'h17, 0);
        check(rd_val === 8'h27 && snap_stb === 4'b0010, "R3 ch byte7", {snap_stb, rd_val}, 16'h227);
        access(0, 5'h18, 0);
        check(rd_val === 8'hFF && snap_stb === 4'b0000, "R3 ch byte8", {snap_stb, rd_val}, 16'h0FF);
        access(1, 5'h04, 8'h06);
        access(1, 5'h1F, 8'hA5);
        check(snap_stb === 4'b1000 && lcr_hi === 1'b1, "R2 high bank", {snap_stb, lcr_hi}, 5'h11);
        access(1, 5'h04, 8'h05);
        access(0, 5'h10, 0);
        check(rd_val === 8'hFF && snap_stb === 4'b0000, "R2 unassigned index", {snap_stb, rd_val}, 16'h0FF);

        // R2/R3/R4/R5: seeded random window traffic
        for (int i = 0; i < 300; i++) begin
            ix = 8'($urandom_range(0, 7));
            o  = 4'($urandom_range(0, 15));
            d  = 8'($urandom);
            w  = 1'($urandom);
            access(1, 5'h04, ix);
            access(w, {1'b1, o}, d);
            check(snap_stb === stb_exp(ix, o), "R2 strobe", snap_stb, stb_exp(ix, o));
            check(snap_off === o && snap_we === w && (!w || snap_wd === d),
                  "R4 downstream bus", {snap_we, snap_off, snap_wd}, {w, o, d});
            if (!w)
                check(rd_val === win_exp(ix, o), "R5 window read", rd_val, win_exp(ix, o));
        end

        // R5/R12: reserved addresses
        access(1, 5'h04, 8'h04);
        access(1, 5'h03, 8'h81);
        foreach (d[k]) begin
            access(1, 5'(k == 0 ? 0 : k == 1 ? 1 : 4 + k), 8'h5A);
            check(snap_stb === 4'b0000, "R12 no strobe", snap_stb, 0);
        end
        access(0, 5'h0F, 0);
        check(rd_val === 8'hFF, "R5 reserved read", rd_val, 8'hFF);
        access(0, 5'h04, 0);
        check(rd_val === 8'h04, "R12 index kept", rd_val, 8'h04);
        access(0, 5'h03, 0);
        check(rd_val === 8'h81, "R12 aux kept", rd_val, 8'h81);

        // R8: auxiliary byte
        access(1, 5'h03, 8'hFF);
        check(aux_isel === 4'hF && aux_bus_en === 1'b1, "R8 aux outputs", {aux_bus_en, aux_isel}, 5'h1F);
        access(0, 5'h03, 0);
        check(rd_val === 8'h8F, "R8 aux readback", rd_val, 8'h8F);

        // R7: reset and test bits
        access(1, 5'h02, 8'h13);
        check(dn_reset === 1'b1 && test_mode === 1'b1, "R7 set", {dn_reset, test_mode}, 2'b11);
        access(1, 5'h02, 8'h02);
        check(dn_reset === 1'b0 && test_mode === 1'b0, "R7 clear", {dn_reset, test_mode}, 0);

        // R6/R9: sources with enable on, timer stopped
        access(1, 5'h02, 8'h0A);
        for (int i = 0; i < 40; i++) begin
            logic [7:0] es;
            lc_irq = 1'($urandom);
            fr_irq = 2'($urandom);
            @(negedge clk);
            check(irq_n === ~(lc_irq | (|fr_irq)), "R9 irq", irq_n, ~(lc_irq | (|fr_irq)));
            es = {5'b0, 1'b1, ~(|fr_irq), ~lc_irq};
            access(0, 5'h02, 0);
            check(rd_val === es, "R6 status", rd_val, es);
        end
        lc_irq = 1'b1;
        fr_irq = 2'b00;
        access(1, 5'h02, 8'h02);
        @(negedge clk);
        check(irq_n === 1'b1, "R9 disabled", irq_n, 1);
        lc_irq = 1'b0;

        // R10: stopped timer never sets
        idle(2 * TMR);
        access(0, 5'h02, 0);
        check(rd_val === 8'h07, "R10 stopped", rd_val, 8'h07);

        // R10: release clear bit and time the flag
        access(1, 5'h02, 8'h04);
        access(1, 5'h02, 8'h00);
        idle(TMR - 2);
        access(0, 5'h02, 0);
        check(rd_val === 8'h07, "R10 before period", rd_val, 8'h07);
        idle(1);
        access(0, 5'h02, 0);
        check(rd_val === 8'h03, "R10 after period", rd_val, 8'h03);

        // R11: 1 alone keeps the flag, falling write clears it
        access(1, 5'h02, 8'h04);
        idle(3);
        access(0, 5'h02, 0);
        check(rd_val === 8'h03, "R11 held", rd_val, 8'h03);
        access(1, 5'h02, 8'h02);
        access(0, 5'h02, 0);
        check(rd_val === 8'h07, "R11 cleared", rd_val, 8'h07);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule